// File: doc/BRIEF.md
# Deserializer bit-slip alignment controller

This block sits next to a source-synchronous receiver in the divided parallel clock domain. It registers each deserialized word on entry and compares the registered copy with a training word supplied on `pattern_i`. When the word does not match, it asks the deserializer to shift its word boundary by one bit, using a slip request. It then waits for the shifted data to arrive and compares again. After a set number of matching words in a row it reports lock.

Each slip request leaves through an output register. It is exactly two parallel clocks wide, and it is followed by a guaranteed low stretch, so a deserializer that acts on the rising edge sees one shift per request. Once a lock is held, a short burst of bad words is tolerated. A longer run of bad words drops the lock and starts the search again. If a full word width of slips passes without a match, the block raises a sticky failure flag and stops requesting. The flag is cleared by reset or by `restart_i`.

Top module: `slip_align_ctrl`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it is released, `slip_o`, `locked_o` and `align_fail_o` are all low.
- R2: Every high stretch of `slip_o` lasts exactly two clock cycles.
- R3: Between two high stretches of `slip_o`, the output stays low for at least three clock cycles.
- R4: Each mismatching comparison made during the search produces exactly one slip pulse. A word that starts WORD_W-k bit rotations away from `pattern_i` (0 <= k < WORD_W, with all rotations of the pattern distinct) therefore reaches lock after exactly k pulses, when the receiver rotates one bit per pulse.
- R5: `locked_o` rises after LOCK_CNT (default 4) consecutive registered words equal `pattern_i`. While `locked_o` is high, `slip_o` stays low.
- R6: While locked, fewer than UNLOCK_CNT (default 2) consecutive mismatching words leave `locked_o` high. UNLOCK_CNT consecutive mismatches drop `locked_o` and restart the search.
- R7: If a mismatch is seen after WORD_W slips with no lock, `align_fail_o` goes high and stays high. No further slip pulse is issued, and the total number of pulses is exactly WORD_W.
- R8: A one-cycle pulse on `restart_i` clears `align_fail_o` and starts a new search, which locks on an aligned stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parallel (divided) receive clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| restart_i | input | 1 | Synchronous restart of the search; clears the failure flag |
| data_i | input | WORD_W | Deserialized parallel word |
| pattern_i | input | WORD_W | Training word to align to |
| slip_o | output | 1 | Registered bit-slip request, two cycles high |
| locked_o | output | 1 | Alignment achieved |
| align_fail_o | output | 1 | Sticky: no alignment found within WORD_W slips |

## Verification
The receiver model rotates the training word by one bit on each rising edge of `slip_o`. It is started at every one of the WORD_W rotation offsets. This separates a controller that issues one pulse per mismatch from one that double-slips or misses a check, because the pulse count must equal the offset exactly. A stream that is inverted for one word and then for two words shows whether the unlock threshold is counted. An all-zero stream that can never match exercises the sticky failure, the silence that follows it and the restart.

// File: rtl/slip_align_pkg.sv
package slip_align_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_PULSE,
    ST_GAP,
    ST_SETTLE,
    ST_LOCKED,
    ST_FAIL
  } align_state_e;
endpackage

// File: rtl/slip_sync_reg.sv
module slip_sync_reg #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/slip_align_fsm.sv
module slip_align_fsm
  import slip_align_pkg::*;
#(
  parameter int unsigned WORD_W     = 10,
  parameter int unsigned LOCK_CNT   = 4,
  parameter int unsigned UNLOCK_CNT = 2,
  parameter int unsigned GAP_CYC    = 3,
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic match_i,
  output logic req_o,
  output logic locked_o,
  output logic fail_o
);
  localparam int unsigned TMR_MAX = (GAP_CYC > SETTLE_CYC) ? GAP_CYC : SETTLE_CYC;
  localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);
  localparam int unsigned SLIP_W  = $clog2(WORD_W + 1);
  localparam int unsigned MCH_W   = $clog2(LOCK_CNT + 1);
  localparam int unsigned MIS_W   = $clog2(UNLOCK_CNT + 1);

  align_state_e       state_q, state_d;
  logic [TMR_W-1:0]   tmr_q, tmr_d;
  logic [SLIP_W-1:0]  slips_q, slips_d;
  logic [MCH_W-1:0]   hits_q, hits_d;
  logic [MIS_W-1:0]   miss_q, miss_d;

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    slips_d = slips_q;
    hits_d  = hits_q;
    miss_d  = miss_q;
    unique case (state_q)
      ST_IDLE: begin
        slips_d = '0;
        hits_d  = '0;
        miss_d  = '0;
        state_d = ST_CHECK;
      end
      ST_CHECK: begin
        if (match_i) begin
          if (hits_q == MCH_W'(LOCK_CNT - 1)) begin
            state_d = ST_LOCKED;
            miss_d  = '0;
          end else begin
            hits_d = hits_q + 1'b1;
          end
        end else begin
          hits_d = '0;
          if (slips_q == SLIP_W'(WORD_W)) begin
            state_d = ST_FAIL;
          end else begin
            slips_d = slips_q + 1'b1;
            tmr_d   = '0;
            state_d = ST_PULSE;
          end
        end
      end
      ST_PULSE: begin
        // two-cycle request
        if (tmr_q == TMR_W'(1)) begin
          tmr_d   = '0;
          state_d = ST_GAP;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      ST_GAP: begin
        if (tmr_q == TMR_W'(GAP_CYC - 1)) begin
          tmr_d   = '0;
          state_d = ST_SETTLE;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      ST_SETTLE: begin
        if (tmr_q == TMR_W'(SETTLE_CYC - 1)) begin
          tmr_d   = '0;
          hits_d  = '0;
          state_d = ST_CHECK;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      ST_LOCKED: begin
        if (match_i) begin
          miss_d = '0;
        end else if (miss_q == MIS_W'(UNLOCK_CNT - 1)) begin
          miss_d  = '0;
          hits_d  = '0;
          slips_d = '0;
          state_d = ST_CHECK;
        end else begin
          miss_d = miss_q + 1'b1;
        end
      end
      ST_FAIL:  state_d = ST_FAIL;
      default:  state_d = ST_IDLE;
    endcase
    if (restart_i) begin
      state_d = ST_IDLE;
      tmr_d   = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      slips_q <= '0;
      hits_q  <= '0;
      miss_q  <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      slips_q <= slips_d;
      hits_q  <= hits_d;
      miss_q  <= miss_d;
    end
  end

  assign req_o    = (state_q == ST_PULSE);
  assign locked_o = (state_q == ST_LOCKED);
  assign fail_o   = (state_q == ST_FAIL);
endmodule

// File: rtl/slip_align_ctrl.sv
module slip_align_ctrl #(
  parameter int unsigned WORD_W     = 10,
  parameter int unsigned LOCK_CNT   = 4,
  parameter int unsigned UNLOCK_CNT = 2,
  parameter int unsigned GAP_CYC    = 3,
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [WORD_W-1:0] pattern_i,
  output logic              slip_o,
  output logic              locked_o,
  output logic              align_fail_o
);
  logic [WORD_W-1:0] data_q;
  logic              req_raw;

  slip_sync_reg #(.WIDTH(WORD_W)) u_in_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (data_i),
    .q_o   (data_q)
  );

  slip_align_fsm #(
    .WORD_W    (WORD_W),
    .LOCK_CNT  (LOCK_CNT),
    .UNLOCK_CNT(UNLOCK_CNT),
    .GAP_CYC   (GAP_CYC),
    .SETTLE_CYC(SETTLE_CYC)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart_i),
    .match_i  (data_q == pattern_i),
    .req_o    (req_raw),
    .locked_o (locked_o),
    .fail_o   (align_fail_o)
  );

  slip_sync_reg #(.WIDTH(1)) u_out_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_raw),
    .q_o   (slip_o)
  );
endmodule

// File: rtl/slip_align_ctrl_chk.sv
module slip_align_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic restart_i,
  input logic slip_o,
  input logic locked_o,
  input logic align_fail_o
);
  p_pulse_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slip_o) |=> slip_o);
  p_pulse_end_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slip_o && $past(slip_o)) |=> !slip_o);
  p_min_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(slip_o) |-> (!slip_o ##1 !slip_o ##1 !slip_o));
  p_quiet_locked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> !slip_o);
  p_fail_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (align_fail_o && !restart_i) |=> align_fail_o);
  p_fail_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_fail_o |=> !slip_o);
  p_status_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(locked_o && align_fail_o));
  p_restart_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !align_fail_o);
endmodule

bind slip_align_ctrl slip_align_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .restart_i   (restart_i),
  .slip_o      (slip_o),
  .locked_o    (locked_o),
  .align_fail_o(align_fail_o)
);

// File: tb/slip_align_ctrl_tb_top.sv
module slip_align_ctrl_tb_top;
  localparam int W = 10;
  localparam logic [W-1:0] PAT = 10'b0011111000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic restart_i = 1'b0;
  logic [W-1:0] data_i;
  logic slip_o, locked_o, align_fail_o;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int off_init = 0;
  int mode = 0; // 0 aligned model, 1 inverted, 2 all zero
  int off, slips, width_err, gap_err, hi_len, lo_len;
  bit prev, seen_fall;

  always #4 clk_i = ~clk_i;

  function automatic logic [W-1:0] rotl(logic [W-1:0] p, int n);
    logic [W-1:0] r = p;
    for (int i = 0; i < n; i++) r = {r[W-2:0], r[W-1]};
    return r;
  endfunction

  always_comb begin
    case (mode)
      0:       data_i = rotl(PAT, off);
      1:       data_i = ~rotl(PAT, off);
      default: data_i = '0;
    endcase
  end

  slip_align_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart_i),
    .data_i(data_i), .pattern_i(PAT),
    .slip_o(slip_o), .locked_o(locked_o), .align_fail_o(align_fail_o)
  );

  // receiver model and pulse-shape monitor
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      off = off_init; slips = 0; width_err = 0; gap_err = 0;
      hi_len = 0; lo_len = 0; prev = 0; seen_fall = 0;
    end else begin
      if (slip_o && !prev) begin
        slips++;
        off = (off + 1) % W;
        if (seen_fall && lo_len < 3) gap_err++;
        hi_len = 1;
      end else if (slip_o) hi_len++;
      if (!slip_o && prev) begin
        if (hi_len != 2) width_err++;
        seen_fall = 1;
        lo_len = 1;
      end else if (!slip_o) lo_len++;
      prev = slip_o;
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(int k, int m);
    rst_ni = 1'b0;
    off_init = k;
    mode = m;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wait_lock(output bit ok);
    ok = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_i);
      if (locked_o) begin ok = 1; break; end
    end
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    off_init = 3;
    mode = 0;
    @(negedge clk_i);
    check("R1 slip in reset", int'(slip_o), 0);
    check("R1 locked in reset", int'(locked_o), 0);
    check("R1 fail in reset", int'(align_fail_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 slip after release", int'(slip_o), 0);
    check("R1 locked after release", int'(locked_o), 0);
  endtask

  task automatic t_offsets;
    bit ok;
    for (int k = 0; k < W; k++) begin
      do_reset(k, 0);
      wait_lock(ok);
      check($sformatf("R5 lock at offset %0d", k), int'(ok), 1);
      check($sformatf("R4 pulses at offset %0d", k), slips, (W - k) % W);
      check($sformatf("R2 width at offset %0d", k), width_err, 0);
      check($sformatf("R3 gap at offset %0d", k), gap_err, 0);
    end
  endtask

  task automatic t_unlock;
    bit ok, dropped;
    do_reset(0, 0);
    wait_lock(ok);
    check("R6 initial lock", int'(ok), 1);
    dropped = 0;
    mode = 1;
    @(negedge clk_i);
    mode = 0;
    repeat (8) begin
      @(negedge clk_i);
      if (!locked_o) dropped = 1;
    end
    check("R6 single bad word keeps lock", int'(dropped), 0);
    mode = 1;
    repeat (2) @(negedge clk_i);
    mode = 0;
    repeat (4) begin
      @(negedge clk_i);
      if (!locked_o) dropped = 1;
    end
    check("R6 two bad words drop lock", int'(dropped), 1);
    wait_lock(ok);
    check("R6 relock", int'(ok), 1);
  endtask

  task automatic t_fail_restart;
    int s;
    bit ok;
    do_reset(0, 2);
    ok = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_i);
      if (align_fail_o) begin ok = 1; break; end
    end
    check("R7 fail raised", int'(ok), 1);
    check("R7 pulse total", slips, W);
    s = slips;
    repeat (60) @(negedge clk_i);
    check("R7 no pulses after fail", slips, s);
    check("R7 fail sticky", int'(align_fail_o), 1);
    check("R2 width in fail run", width_err, 0);
    check("R3 gap in fail run", gap_err, 0);
    mode = 0;
    restart_i = 1'b1;
    @(negedge clk_i);
    restart_i = 1'b0;
    check("R8 fail cleared", int'(align_fail_o), 0);
    wait_lock(ok);
    check("R8 lock after restart", int'(ok), 1);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 100000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_offsets();
    t_unlock();
    t_fail_restart();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule